// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a free-running up-counter whose count rate comes from a selectable prescaler. A select field chooses either the bus clock divided by a power of two (from 1 to 64) or the rising edges of an external clock pin. The external pin is brought into the bus clock domain through a two-flop synchronizer before its edges are detected.

The count is twice as wide as the read bus. Software reads it as two bytes, high then low. Reading the high byte snapshots the low byte into a holding register. The following low-byte read returns that snapshot, so the pair of bytes belongs to one instant even though the counter keeps running between the two accesses. A one-cycle clear request zeroes the counter and the prescaler phase. System reset does the same.

Top module: `prescaled_timer`

## Requirements
- R1: While `rst` is high, the counter, the hold-valid flag and `rd_data_o` are all cleared to zero on each clock edge.
- R2: For a select code k from 0 to 6, the counter advances by one every 2^k bus clocks. After a clear takes effect, the count t cycles later equals floor(t / 2^k).
- R3: Select code 7 (all ones) makes the counter advance once per low-to-high transition of `ext_clk_i`. The pin passes through two synchronizer flops before the edge detector, so a level must be held for at least two bus clocks to be seen, and a level held steady adds no counts.
- R4: The counter wraps from all ones to zero.
- R5: A read strobe with `rd_addr_i` = 1 selects the high byte. One edge later `rd_data_o` holds bits [2W-1:W] of the count. If no snapshot is pending, the low byte is captured into the holding register and the hold-valid flag is set.
- R6: A high-byte read while a snapshot is pending leaves the held low byte unchanged.
- R7: A read strobe with `rd_addr_i` = 0 selects the low byte. It returns the held value when a snapshot is pending and the live low byte otherwise. In both cases it clears the hold-valid flag.
- R8: A one-cycle pulse on `clr_req_i` sets an internal clear strobe for one cycle. On the following edge the counter and the prescaler divider go to zero.
- R9: Neither a counter clear nor any amount of time discards a pending snapshot. Only a low-byte read or reset releases it.
- R10: `rd_data_o` is a register. It changes only on the edge that samples a read strobe, and it holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External count clock, asynchronous to `clk` |
| div_sel_i | input | 3 | Prescaler select: 0..6 divide by 2^code, 7 selects external edges |
| clr_req_i | input | 1 | Counter clear request (one-cycle pulse) |
| rd_en_i | input | 1 | Byte read strobe |
| rd_addr_i | input | 1 | Byte address: 1 is the high byte, 0 is the low byte |
| rd_data_o | output | BYTE_W | Registered read data |

## Verification
The bench builds the block with BYTE_W = 4, which gives an 8-bit counter read as two 4-bit halves. With this width a wrap at select code 0 comes after only 256 cycles, and every divide ratio up to 64 can be swept within a few thousand cycles. Expected counts come from floor(t / 2^k) modulo 256, where t is the number of edges since the clear took effect. The short halves also make it easy to find read spacings at which the held low half and the live low half must differ.

// File: rtl/prescaled_timer_pkg.sv
package prescaled_timer_pkg;

  // select field width and the derived prescaler geometry
  localparam int SEL_W    = 3;
  localparam int NUM_SRC  = 2 ** SEL_W;
  localparam int DIV_W    = NUM_SRC - 2;
  localparam logic [SEL_W-1:0] EXT_CODE = {SEL_W{1'b1}};

  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } byte_sel_e;

endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import prescaled_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_rise_i,
  output logic             tick_o
);

  logic [DIV_W-1:0]   div_q;
  logic [NUM_SRC-1:0] src_tick;

  always_ff @(posedge clk) begin
    if (rst || clear_i) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  // one enable per source: divide by 2^i fires when the low i bits are all ones
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == NUM_SRC - 1) begin : g_ext
        assign src_tick[i] = ext_rise_i;
      end else if (i == 0) begin : g_bus
        assign src_tick[i] = 1'b1;
      end else begin : g_div
        assign src_tick[i] = &div_q[i-1:0];
      end
    end
  endgenerate

  assign tick_o = src_tick[sel_i];

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) count_q <= '0;
    else if (tick_i)    count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

endmodule

// File: rtl/ptmr_read_port.sv
module ptmr_read_port
  import prescaled_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              hold_vld_o,
  output logic [BYTE_W-1:0] hold_o
);

  logic [BYTE_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] live_hi;
  logic [BYTE_W-1:0] live_lo;

  assign live_hi = count_i[CNT_W-1:BYTE_W];
  assign live_lo = count_i[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      data_q     <= '0;
    end else if (rd_en_i) begin
      if (byte_sel_e'(rd_addr_i) == BYTE_HI) begin
        data_q <= live_hi;
        if (!hold_vld_q) begin
          hold_q     <= live_lo;
          hold_vld_q <= 1'b1;
        end
      end else begin
        data_q     <= hold_vld_q ? hold_q : live_lo;
        hold_vld_q <= 1'b0;
      end
    end
  end

  assign rd_data_o  = data_q;
  assign hold_vld_o = hold_vld_q;
  assign hold_o     = hold_q;

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import prescaled_timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk_i,
  input  logic [SEL_W-1:0]  div_sel_i,
  input  logic              clr_req_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);

  localparam int CNT_W = 2 * BYTE_W;

  logic              clr_q;
  logic              ext_rise;
  logic              tick;
  logic [CNT_W-1:0]  count_q;
  logic              hold_vld_q;
  logic [BYTE_W-1:0] hold_q;

  // self-clearing clear strobe: set for the cycle after a request
  always_ff @(posedge clk) begin
    if (rst) clr_q <= 1'b0;
    else     clr_q <= clr_req_i;
  end

  ptmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  ptmr_prescaler u_pscl (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (clr_q),
    .sel_i      (div_sel_i),
    .ext_rise_i (ext_rise),
    .tick_o     (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (clr_q),
    .tick_i  (tick),
    .count_o (count_q)
  );

  ptmr_read_port #(.BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .count_i    (count_q),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .hold_vld_o (hold_vld_q),
    .hold_o     (hold_q)
  );

endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en_i,
  input logic              rd_addr_i,
  input logic              clr_req_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic [CNT_W-1:0]  count_q,
  input logic              hold_vld_q,
  input logic [BYTE_W-1:0] hold_q
);

  logic [CNT_W-1:0]  count_inc;
  logic [BYTE_W-1:0] lo_expect;
  assign count_inc = count_q + 1'b1;
  assign lo_expect = hold_vld_q ? hold_q : count_q[BYTE_W-1:0];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_q == '0 && !hold_vld_q && rd_data_o == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_q == $past(count_q) || count_q == $past(count_inc) || count_q == '0));

  p_hi_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i) |=> (hold_vld_q && rd_data_o == $past(count_q[CNT_W-1:BYTE_W])));

  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i && hold_vld_q) |=> (hold_vld_q && hold_q == $past(hold_q)));

  p_lo_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !rd_addr_i) |=> (!hold_vld_q && rd_data_o == $past(lo_expect)));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr_req_i |=> ##1 (count_q == '0));

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));

endmodule

bind prescaled_timer prescaled_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .clr_req_i  (clr_req_i),
  .rd_data_o  (rd_data_o),
  .count_q    (count_q),
  .hold_vld_q (hold_vld_q),
  .hold_q     (hold_q)
);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BW         = 4;
  localparam int CMASK      = (1 << (2 * BW)) - 1;
  localparam int BMASK      = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_clk = 1'b0;
  logic [2:0]    div_sel = 3'd3;
  logic          clr_req = 1'b0;
  logic          rd_en = 1'b0;
  logic          rd_addr = 1'b0;
  logic [BW-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int clr_edge = 0;

  prescaled_timer #(.BYTE_W(BW)) u_prescaled_timer (
    .clk       (clk),
    .rst       (rst),
    .ext_clk_i (ext_clk),
    .div_sel_i (div_sel),
    .clr_req_i (clr_req),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int expect_cnt(int t, int k);
    return (t >>> k) & CMASK;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    clr_edge = cyc + 1;
  endtask

  // reads high then low on consecutive edges; t is edges since the clear took effect
  task automatic read_word(output int val, output int t);
    int hi;
    @(negedge clk); rd_en = 1'b1; rd_addr = 1'b1; t = cyc - clr_edge;
    @(negedge clk); hi = int'(rd_data); rd_addr = 1'b0;
    @(negedge clk); val = (hi << BW) | int'(rd_data); rd_en = 1'b0;
  endtask

  // single byte read; t is edges since the clear took effect at the sampling edge
  task automatic read_byte(input logic hi, output int val, output int t);
    @(negedge clk); rd_en = 1'b1; rd_addr = hi; t = cyc - clr_edge;
    @(negedge clk); val = int'(rd_data); rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int v, t, v2, t2, t0, t1, t4, last;

    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;
    clr_edge = cyc;
    read_word(v, t);
    check("R1 count from reset", v, expect_cnt(t, 3));

    // R2: every divide ratio, several read spacings
    for (int k = 0; k < 7; k++) begin
      div_sel = 3'(k);
      do_clear();
      for (int r = 0; r < 6; r++) begin
        repeat (r * 7 + (1 << k)) @(negedge clk);
        read_word(v, t);
        check($sformatf("R2 divide code %0d", k), v, expect_cnt(t, k));
      end
    end

    // R8: clear then immediate read gives zero at a slow rate
    div_sel = 3'd4;
    repeat (40) @(negedge clk);
    do_clear();
    read_word(v, t);
    check("R8 count right after clear", v, 0);
    check("R8 clear edge offset", t, 0);

    // R4: wrap at code 0
    div_sel = 3'd0;
    do_clear();
    repeat (248) @(negedge clk);
    read_word(v, t);
    check("R4 before wrap", v, expect_cnt(t, 0));
    repeat (10) @(negedge clk);
    read_word(v2, t2);
    check("R4 after wrap", v2, expect_cnt(t2, 0));
    check("R4 wrapped below earlier value", int'(v2 < v), 1);

    // R5/R6/R7: coherent snapshot across repeated high reads
    do_clear();
    repeat (20) @(negedge clk);
    read_byte(1'b1, v, t0);
    check("R5 high half", v, expect_cnt(t0, 0) >> BW);
    repeat (5) @(negedge clk);
    read_byte(1'b1, v, t1);
    check("R5 second high half is live", v, expect_cnt(t1, 0) >> BW);
    repeat (3) @(negedge clk);
    read_byte(1'b0, v, t);
    check("R6 held low half frozen", v, expect_cnt(t0, 0) & BMASK);
    check("R6 live low half differs", int'((expect_cnt(t, 0) & BMASK) != v), 1);
    read_byte(1'b0, v, t);
    check("R7 low read with no snapshot is live", v, expect_cnt(t, 0) & BMASK);
    last = v;

    // R10: output holds without a read strobe
    repeat (6) @(negedge clk);
    check("R10 rd_data held", int'(rd_data), last);

    // R9: snapshot survives a clear and a long wait
    read_byte(1'b1, v, t4);
    do_clear();
    repeat (300) @(negedge clk);
    read_byte(1'b0, v, t);
    check("R9 snapshot kept across clear", v, (t4 + 0) & BMASK);
    read_word(v, t);
    check("R8 count restarted after clear", v, expect_cnt(t, 0));

    // R3: external edges
    div_sel = 3'd7;
    ext_clk = 1'b0;
    do_clear();
    last = 0;
    for (int b = 1; b <= 3; b++) begin
      for (int p = 0; p < b * 5; p++) begin
        ext_clk = 1'b1; repeat (3) @(negedge clk);
        ext_clk = 1'b0; repeat (3) @(negedge clk);
      end
      last += b * 5;
      repeat (6) @(negedge clk);
      read_word(v, t);
      check($sformatf("R3 external edges batch %0d", b), v, last);
    end
    ext_clk = 1'b1;
    repeat (25) @(negedge clk);
    read_word(v, t);
    check("R3 held high counts once", v, last + 1);
    repeat (10) @(negedge clk);
    read_word(v, t);
    check("R3 steady level adds nothing", v, last + 1);

    summary();
  end

endmodule